// File: doc/BRIEF.md
# Rotating Register Renaming File

This block holds a register file whose upper region is renamed by a rotating base. Logical register numbers below a fixed boundary (32 by default) address storage directly. Numbers at or above the boundary fall in the rotating region, which holds `ROT_REGS` entries. Each of these is shifted by a base offset, modulo the region size, before it reaches storage. Each loop-closing branch moves the base down by one position. As a result, a value written under one logical name is read under the next higher name after every loop iteration. A software-pipelined loop can then hand results from stage to stage without moving any data.

Two combinational read ports and one write port all take logical indices. The branch unit reports each resolved branch with a valid strobe and a 3-bit kind code, and only the four loop-closing kinds rotate the base. A clear input puts the base back at zero before a loop starts. A write in the same cycle as a rotation uses the base as it stood before the rotation. A read that hits the entry being written in that cycle returns the new data.

Top module: `rot_regfile`

## Requirements
- R1: After reset the rotating base is zero and every register reads as zero.
- R2: Logical indices below 32 address storage directly, and rotation never changes which entry they name.
- R3: A value written to logical 32 reads back at logical 32+k after k rotations, for every k from 0 to N-1 (N = 64 by default). After six rotations it therefore reads at 38.
- R4: A rotation happens only when `br_valid` is high and `br_kind` is one of the loop-closing codes 4 (counted top), 5 (counted exit), 6 (while top) or 7 (while exit). Codes 0 to 3 (plain, call, return, counted non-rotating), and any code with `br_valid` low, leave the base unchanged.
- R5: `clr_base` sets the base to zero at the next edge and wins over a rotation requested in the same cycle.
- R6: The base wraps inside the region. A value written at logical 32+N-1 reads at logical 32 after one rotation.
- R7: A write issued in the same cycle as a rotation lands in the entry named under the pre-rotation base, so it reads at the next higher logical index afterwards.
- R8: A read whose index names the entry being written in the same cycle returns the write data (write-first).
- R9: Logical indices at or above 32+N read as zero, and writes to them change nothing.
- R10: The two read ports work independently and return different registers in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| clr_base | input | 1 | Return rotating base to zero |
| br_valid | input | 1 | A branch resolved this cycle |
| br_kind | input | 3 | Branch kind code (4 to 7 rotate) |
| we | input | 1 | Write enable |
| waddr | input | IDX_W (7) | Logical write index |
| wdata | input | DATA_W (32) | Write data |
| raddr_a | input | IDX_W (7) | Logical index, read port A |
| rdata_a | output | DATA_W (32) | Read data, port A |
| raddr_b | input | IDX_W (7) | Logical index, read port B |
| rdata_b | output | DATA_W (32) | Read data, port B |

## Verification
Read data is combinational, so it is due in the same cycle as the read index. The bench applies each index just after a rising edge and samples at the following falling edge. Writes, rotations and clears take effect at the next rising edge, so their effect is checked one cycle later through a read on one of the ports. Bypass checks hold the write and the matching read index together and sample before the edge that commits the write.

// File: rtl/rot_regfile_pkg.sv
package rot_regfile_pkg;

    typedef enum logic [2:0] {
        BK_PLAIN       = 3'd0,
        BK_CALL        = 3'd1,
        BK_RETURN      = 3'd2,
        BK_COUNT_PLAIN = 3'd3,
        BK_COUNT_TOP   = 3'd4,
        BK_COUNT_EXIT  = 3'd5,
        BK_WHILE_TOP   = 3'd6,
        BK_WHILE_EXIT  = 3'd7
    } br_kind_e;

endpackage

// File: rtl/rot_regfile_rot_decode.sv
module rot_regfile_rot_decode
    import rot_regfile_pkg::*;
(
    input  logic     br_valid,
    input  br_kind_e br_kind,
    output logic     rotate
);
    logic loop_kind;

    always_comb begin
        unique case (br_kind)
            BK_PLAIN, BK_CALL, BK_RETURN, BK_COUNT_PLAIN: loop_kind = 1'b0;
            BK_COUNT_TOP, BK_COUNT_EXIT,
            BK_WHILE_TOP, BK_WHILE_EXIT:                  loop_kind = 1'b1;
            default:                                      loop_kind = 1'b0;
        endcase
        rotate = br_valid && loop_kind;
    end
endmodule

// File: rtl/rot_regfile_base_ctr.sv
module rot_regfile_base_ctr #(
    parameter int ROT_REGS = 64,
    localparam int ROT_W   = (ROT_REGS > 1) ? $clog2(ROT_REGS) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_base,
    input  logic             rotate,
    output logic [ROT_W-1:0] base
);
    localparam logic [ROT_W-1:0] LAST_POS = ROT_W'(ROT_REGS - 1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            base <= '0;
        end else if (clr_base) begin
            base <= '0;
        end else if (rotate) begin
            base <= (base == '0) ? LAST_POS : base - ROT_W'(1);
        end
    end
endmodule

// File: rtl/rot_regfile_index_map.sv
module rot_regfile_index_map #(
    parameter int STATIC_REGS = 32,
    parameter int ROT_REGS    = 64,
    localparam int TOTAL_REGS = STATIC_REGS + ROT_REGS,
    localparam int IDX_W      = $clog2(TOTAL_REGS),
    localparam int ROT_W      = (ROT_REGS > 1) ? $clog2(ROT_REGS) : 1
) (
    input  logic [IDX_W-1:0] lidx,
    input  logic [ROT_W-1:0] base,
    output logic [IDX_W-1:0] pidx,
    output logic             in_range
);
    localparam logic [IDX_W:0] TOTAL_C  = (IDX_W+1)'(TOTAL_REGS);
    localparam logic [IDX_W:0] REGION_C = (IDX_W+1)'(ROT_REGS);

    logic [IDX_W:0] shifted;

    always_comb begin
        shifted  = {1'b0, lidx} + (IDX_W+1)'(base);
        in_range = ({1'b0, lidx} < TOTAL_C);
        if (!in_range) begin
            pidx = '0;
        end else if (lidx < IDX_W'(STATIC_REGS)) begin
            pidx = lidx;
        end else if (shifted >= TOTAL_C) begin
            pidx = IDX_W'(shifted - REGION_C);
        end else begin
            pidx = IDX_W'(shifted);
        end
    end
endmodule

// File: rtl/rot_regfile_store.sv
module rot_regfile_store #(
    parameter int TOTAL_REGS = 96,
    parameter int DATA_W     = 32,
    localparam int IDX_W     = $clog2(TOTAL_REGS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_ok_a,
    input  logic [IDX_W-1:0]  rd_idx_a,
    output logic [DATA_W-1:0] rd_data_a,
    input  logic              rd_ok_b,
    input  logic [IDX_W-1:0]  rd_idx_b,
    output logic [DATA_W-1:0] rd_data_b
);
    logic [DATA_W-1:0] cells [TOTAL_REGS];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < TOTAL_REGS; i++) begin
                cells[i] <= '0;
            end
        end else if (wr_en) begin
            cells[wr_idx] <= wr_data;
        end
    end

    always_comb begin
        if (!rd_ok_a)                          rd_data_a = '0;
        else if (wr_en && wr_idx == rd_idx_a)  rd_data_a = wr_data;
        else                                   rd_data_a = cells[rd_idx_a];

        if (!rd_ok_b)                          rd_data_b = '0;
        else if (wr_en && wr_idx == rd_idx_b)  rd_data_b = wr_data;
        else                                   rd_data_b = cells[rd_idx_b];
    end
endmodule

// File: rtl/rot_regfile.sv
module rot_regfile
    import rot_regfile_pkg::*;
#(
    parameter int STATIC_REGS = 32,
    parameter int ROT_REGS    = 64,
    parameter int DATA_W      = 32,
    localparam int TOTAL_REGS = STATIC_REGS + ROT_REGS,
    localparam int IDX_W      = $clog2(TOTAL_REGS),
    localparam int ROT_W      = (ROT_REGS > 1) ? $clog2(ROT_REGS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr_base,
    input  logic              br_valid,
    input  logic [2:0]        br_kind,
    input  logic              we,
    input  logic [IDX_W-1:0]  waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [IDX_W-1:0]  raddr_a,
    output logic [DATA_W-1:0] rdata_a,
    input  logic [IDX_W-1:0]  raddr_b,
    output logic [DATA_W-1:0] rdata_b
);
    localparam int NPORT = 3;  // 0: write, 1: read A, 2: read B

    logic             rotate;
    logic [ROT_W-1:0] rot_base;
    logic [IDX_W-1:0] lidx [NPORT];
    logic [IDX_W-1:0] pidx [NPORT];
    logic             ok   [NPORT];

    assign lidx[0] = waddr;
    assign lidx[1] = raddr_a;
    assign lidx[2] = raddr_b;

    rot_regfile_rot_decode u_decode (
        .br_valid (br_valid),
        .br_kind  (br_kind_e'(br_kind)),
        .rotate   (rotate)
    );

    rot_regfile_base_ctr #(.ROT_REGS(ROT_REGS)) u_base (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr_base (clr_base),
        .rotate   (rotate),
        .base     (rot_base)
    );

    for (genvar p = 0; p < NPORT; p++) begin : g_map
        rot_regfile_index_map #(
            .STATIC_REGS (STATIC_REGS),
            .ROT_REGS    (ROT_REGS)
        ) u_map (
            .lidx     (lidx[p]),
            .base     (rot_base),
            .pidx     (pidx[p]),
            .in_range (ok[p])
        );
    end

    rot_regfile_store #(
        .TOTAL_REGS (TOTAL_REGS),
        .DATA_W     (DATA_W)
    ) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (we && ok[0]),
        .wr_idx    (pidx[0]),
        .wr_data   (wdata),
        .rd_ok_a   (ok[1]),
        .rd_idx_a  (pidx[1]),
        .rd_data_a (rdata_a),
        .rd_ok_b   (ok[2]),
        .rd_idx_b  (pidx[2]),
        .rd_data_b (rdata_b)
    );
endmodule

// File: rtl/rot_regfile_chk.sv
module rot_regfile_chk #(
    parameter int STATIC_REGS = 32,
    parameter int ROT_REGS    = 64,
    parameter int DATA_W      = 32,
    localparam int TOTAL_REGS = STATIC_REGS + ROT_REGS,
    localparam int IDX_W      = $clog2(TOTAL_REGS),
    localparam int ROT_W      = (ROT_REGS > 1) ? $clog2(ROT_REGS) : 1
) (
    input logic              clk,
    input logic              rst_n,
    input logic              clr_base,
    input logic              br_valid,
    input logic [2:0]        br_kind,
    input logic              we,
    input logic [IDX_W-1:0]  waddr,
    input logic [DATA_W-1:0] wdata,
    input logic [IDX_W-1:0]  raddr_a,
    input logic [DATA_W-1:0] rdata_a,
    input logic [ROT_W-1:0]  base
);
    localparam logic [ROT_W-1:0] LAST_POS = ROT_W'(ROT_REGS - 1);
    localparam logic [IDX_W-1:0] LIMIT    = IDX_W'(TOTAL_REGS);

    // R3 / R6: a loop-closing branch steps the base down by one, wrapping
    a_r3_loop_branch_steps: assert property (@(posedge clk) disable iff (!rst_n)
        (br_valid && br_kind[2] && !clr_base) |=>
        (base == (($past(base) == '0) ? LAST_POS : $past(base) - ROT_W'(1))));

    // R4: any other branch, or none, leaves the base alone
    a_r4_other_branch_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_base && !(br_valid && br_kind[2])) |=> $stable(base));

    // R5: clear wins and lands the base at zero
    a_r5_clear_to_zero: assert property (@(posedge clk) disable iff (!rst_n)
        clr_base |=> (base == '0));

    // R8: same-cycle read of the written index returns write data
    a_r8_write_first: assert property (@(posedge clk) disable iff (!rst_n)
        (we && waddr == raddr_a && waddr < LIMIT) |-> (rdata_a == wdata));

    // R9: out-of-range reads return zero
    a_r9_out_of_range_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (raddr_a >= LIMIT) |-> (rdata_a == '0));
endmodule

bind rot_regfile rot_regfile_chk #(
    .STATIC_REGS (STATIC_REGS),
    .ROT_REGS    (ROT_REGS),
    .DATA_W      (DATA_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr_base (clr_base),
    .br_valid (br_valid),
    .br_kind  (br_kind),
    .we       (we),
    .waddr    (waddr),
    .wdata    (wdata),
    .raddr_a  (raddr_a),
    .rdata_a  (rdata_a),
    .base     (rot_base)
);

// File: tb/rot_regfile_bench.sv
`timescale 1ns/1ps
module rot_regfile_bench;
    localparam int STATIC_REGS = 32;
    localparam int ROT_REGS    = 64;
    localparam int DATA_W      = 32;
    localparam int TOTAL       = STATIC_REGS + ROT_REGS;
    localparam int IDX_W       = $clog2(TOTAL);

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              clr_base = 1'b0;
    logic              br_valid = 1'b0;
    logic [2:0]        br_kind = 3'd0;
    logic              we = 1'b0;
    logic [IDX_W-1:0]  waddr = '0;
    logic [DATA_W-1:0] wdata = '0;
    logic [IDX_W-1:0]  raddr_a = '0;
    logic [IDX_W-1:0]  raddr_b = '0;
    logic [DATA_W-1:0] rdata_a;
    logic [DATA_W-1:0] rdata_b;

    int n_checks = 0;
    int n_fails  = 0;

    always #2 clk = ~clk;  // 250 MHz

    rot_regfile #(
        .STATIC_REGS (STATIC_REGS),
        .ROT_REGS    (ROT_REGS),
        .DATA_W      (DATA_W)
    ) u_rot_regfile (
        .clk(clk), .rst_n(rst_n), .clr_base(clr_base),
        .br_valid(br_valid), .br_kind(br_kind),
        .we(we), .waddr(waddr), .wdata(wdata),
        .raddr_a(raddr_a), .rdata_a(rdata_a),
        .raddr_b(raddr_b), .rdata_b(rdata_b)
    );

    task automatic check(string req, logic [DATA_W-1:0] act, logic [DATA_W-1:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic cyc();
        @(posedge clk);
        #1;
    endtask

    task automatic wr(int idx, logic [DATA_W-1:0] val);
        we = 1'b1; waddr = IDX_W'(idx); wdata = val;
        cyc();
        we = 1'b0;
    endtask

    task automatic rot(logic [2:0] kind);
        br_valid = 1'b1; br_kind = kind;
        cyc();
        br_valid = 1'b0;
    endtask

    task automatic clr();
        clr_base = 1'b1;
        cyc();
        clr_base = 1'b0;
    endtask

    task automatic rd(string req, int ia, logic [DATA_W-1:0] ea, int ib, logic [DATA_W-1:0] eb);
        raddr_a = IDX_W'(ia); raddr_b = IDX_W'(ib);
        @(negedge clk);
        check(req, rdata_a, ea);
        check(req, rdata_b, eb);
    endtask

    task automatic t_reset();   // R1
        rd("R1", 0, 0, 32, 0);
        rd("R1", 95, 0, 17, 0);
    endtask

    task automatic t_static();  // R2
        wr(7, 32'h5157_0007);
        for (int i = 0; i < 3; i++) rot(3'd4);
        rd("R2", 7, 32'h5157_0007, 8, 0);
    endtask

    task automatic t_sweep();   // R3, R10
        clr();
        wr(32, 32'hC0DE_0032);
        for (int k = 0; k < ROT_REGS; k++) begin
            rd("R3", 32 + k, 32'hC0DE_0032, 33 + k, 0);
            rot(3'd4 + 3'(k % 4));
        end
        rd("R3", 32, 32'hC0DE_0032, 7, 32'h5157_0007);
    endtask

    task automatic t_kinds();   // R4
        clr();
        wr(32, 32'hAAAA_0004);
        for (int k = 0; k < 4; k++) begin
            rot(3'(k));
            rd("R4", 32, 32'hAAAA_0004, 33, 0);
        end
        br_kind = 3'd4; br_valid = 1'b0;
        cyc();
        rd("R4", 32, 32'hAAAA_0004, 33, 0);
        for (int k = 4; k < 8; k++) begin
            rot(3'(k));
            rd("R4", 32 + k - 3, 32'hAAAA_0004, 32, 0);
        end
    endtask

    task automatic t_clear();   // R5
        clr();
        wr(32, 32'h0000_C1EA);
        rot(3'd6); rot(3'd6);
        rd("R5", 34, 32'h0000_C1EA, 32, 0);
        clr();
        rd("R5", 32, 32'h0000_C1EA, 33, 0);
        clr_base = 1'b1; br_valid = 1'b1; br_kind = 3'd5;
        cyc();
        clr_base = 1'b0; br_valid = 1'b0;
        rd("R5", 32, 32'h0000_C1EA, 33, 0);
    endtask

    task automatic t_write_rotate();  // R7
        clr();
        we = 1'b1; waddr = IDX_W'(32); wdata = 32'h7777_0033;
        br_valid = 1'b1; br_kind = 3'd4;
        cyc();
        we = 1'b0; br_valid = 1'b0;
        rd("R7", 33, 32'h7777_0033, 32, 0);
    endtask

    task automatic t_wrap();    // R6
        clr();
        wr(STATIC_REGS + ROT_REGS - 1, 32'hFFFF_0095);
        rot(3'd7);
        rd("R6", 32, 32'hFFFF_0095, 95, 0);
    endtask

    task automatic t_bypass();  // R8
        clr();
        we = 1'b1; waddr = IDX_W'(40); wdata = 32'hB1B1_0040;
        raddr_a = IDX_W'(40); raddr_b = IDX_W'(7);
        @(negedge clk);
        check("R8", rdata_a, 32'hB1B1_0040);
        check("R8", rdata_b, 32'h5157_0007);
        cyc();
        we = 1'b1; waddr = IDX_W'(9); wdata = 32'hB1B1_0009;
        raddr_a = IDX_W'(9); raddr_b = IDX_W'(40);
        @(negedge clk);
        check("R8", rdata_a, 32'hB1B1_0009);
        check("R8", rdata_b, 32'hB1B1_0040);
        cyc();
        we = 1'b0;
    endtask

    task automatic t_range();   // R9
        clr();
        wr(36, 32'h0000_0036);
        wr(100, 32'hDEAD_0100);
        rd("R9", 100, 0, 36, 32'h0000_0036);
        rd("R9", 127, 0, 100, 0);
    endtask

    initial begin
        #(200000 * 4);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        cyc();
        t_reset();
        t_static();
        t_sweep();
        t_kinds();
        t_clear();
        t_write_rotate();
        t_wrap();
        t_bypass();
        t_range();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end
endmodule